// File: doc/BRIEF.md
# Shadow Register Transfer Bank

This block holds a set of 32-bit configuration registers in two layers. Software writes a master layer over a simple memory-mapped bus; the clock logic downstream only ever sees the local layer. A master value reaches its local copy only when software asks for it. It can ask for one register by index, or for a masked group that a background engine walks through.

Word index `i` sits at byte offset `4*i`. The lower 32 words (offsets below 0x80) have both a master and a local copy. Offsets from 0x80 upward are control and status registers that exist only once. Word 0 holds a fixed hardware revision. Word 18 (offset 0x48) doubles as the readout selector: its local copy names which local register appears at the readout offset. This lets software see the local layer without a wide read path per register.

Control offsets: 0x80 group mask, 0x84 group start, 0x8C group done, 0x90 single-transfer control, 0x94 single-transfer status, 0x98 readout.

Top module: `shadow_xfer_bank`

## Requirements
- R1: After reset every master (except word 0) and every local copy is zero, the group mask, start, control and status registers read zero, the done flag reads zero, and offset 0x00 reads the HW_VER parameter.
- R2: A bus write to an offset below 0x80 updates that master word and a read of the same offset returns it, except offset 0x00, which ignores writes and always returns HW_VER.
- R3: A master write alone leaves every local copy (the local_flat port and the readout value) unchanged.
- R4: Writing offset 0x90 with bit 0 = 1 after it held 0 copies master word `idx` (idx = bits 5:1) into its local copy on the next clock edge, and sets bit `idx` of offset 0x94 on that same edge.
- R5: Writing 0x90 with bit 0 = 0 clears all of 0x94 on that edge; writing bit 0 = 1 while it already holds 1 starts no copy.
- R6: Offset 0x98 returns local word `n`, where `n` is bits 4:0 of the local copy of word 18 (offset 0x48).
- R7: A 0-to-1 change of bit 0 at offset 0x84 starts a group transfer of the words whose bits are set at 0x80. They are copied in ascending index order, one per XFER_CYC cycles; the k-th copy lands XFER_CYC*k+1 edges after the start write. Bit 0 of 0x8C is set on the edge of the last copy.
- R8: A new start clears the done flag on the edge after the start write; a start with an empty mask sets done on that edge instead.
- R9: Offsets 0x80, 0x84, 0x90 and 0x94 read back their stored values. Any other offset at or above 0x80 (other than 0x8C and 0x98) reads zero and ignores writes.
- R10: A group transfer leaves the local copies of words outside the mask untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| local_flat | output | 32*DW | All local copies, word i at bits i*DW +: DW |

## Verification
A wrong master or local word shows up at once: the master on the next bus read of that offset, and the local on local_flat or through the readout selector one edge after the copy should have landed. A broken edge detector or status update in the single engine gives a 0x94 value or a local word that is wrong on the very next edge after the control write. A fault in the group engine's ordering or slot counter moves a copy by whole slots. So the bench samples between slot boundaries and expects exactly one more word on each side of every boundary, and a done flag that appears early or late is caught within one slot.

// File: rtl/shx_pkg.sv
package shx_pkg;
   localparam int unsigned NLOC = 32;
   localparam int unsigned IDXW = 5;

   localparam logic [7:0] OFS_MASK  = 8'h80;
   localparam logic [7:0] OFS_START = 8'h84;
   localparam logic [7:0] OFS_DONE  = 8'h8C;
   localparam logic [7:0] OFS_WCTL  = 8'h90;
   localparam logic [7:0] OFS_WSTAT = 8'h94;
   localparam logic [7:0] OFS_RDOUT = 8'h98;

   localparam int unsigned IDX_RDSEL = 18;

   typedef logic [IDXW-1:0] idx_t;

   typedef enum logic {AX_IDLE, AX_RUN} ax_state_e;

   function automatic idx_t first_set(input logic [NLOC-1:0] v);
      idx_t r;
      r = '0;
      for (int i = NLOC - 1; i >= 0; i--) begin
         if (v[i]) r = idx_t'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/shx_bank.sv
module shx_bank
   import shx_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter logic [DW-1:0] HW_VER = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mwr_en,
   input  idx_t               mwr_idx,
   input  logic [DW-1:0]      mwr_data,
   input  logic               s_en,
   input  idx_t               s_idx,
   input  logic               a_en,
   input  idx_t               a_idx,
   output logic [NLOC*DW-1:0] master_flat,
   output logic [NLOC*DW-1:0] local_flat
);
   genvar gi;
   generate
      for (gi = 0; gi < NLOC; gi++) begin : g_word
         logic [DW-1:0] loc_q;
         if (gi == 0) begin : g_ver
            assign master_flat[gi*DW +: DW] = HW_VER;
         end else begin : g_rw
            logic [DW-1:0] mst_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) mst_q <= '0;
               else if (mwr_en && mwr_idx == idx_t'(gi)) mst_q <= mwr_data;
            end
            assign master_flat[gi*DW +: DW] = mst_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) loc_q <= '0;
            else if ((s_en && s_idx == idx_t'(gi)) || (a_en && a_idx == idx_t'(gi)))
               loc_q <= master_flat[gi*DW +: DW];
         end
         assign local_flat[gi*DW +: DW] = loc_q;
      end
   endgenerate

   p_local_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_en && !a_en) |=> $stable(local_flat));
endmodule

// File: rtl/shx_single_xfer.sv
module shx_single_xfer
   import shx_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_lvl,
   input  idx_t            sel_idx,
   input  logic            clr,
   output logic            copy_en,
   output idx_t            copy_idx,
   output logic [NLOC-1:0] stat
);
   logic upd_prev;
   logic rise;

   assign rise     = upd_lvl & ~upd_prev;
   assign copy_en  = rise;
   assign copy_idx = sel_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_prev <= 1'b0;
         stat     <= '0;
      end else begin
         upd_prev <= upd_lvl;
         if (clr) stat <= '0;
         else if (rise) stat[sel_idx] <= 1'b1;
      end
   end

   p_stat_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !clr) |=> stat[$past(sel_idx)]);
   p_stat_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (stat == '0));
   p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !rise) |=> $stable(stat));
endmodule

// File: rtl/shx_auto_xfer.sv
module shx_auto_xfer
   import shx_pkg::*;
#(
   parameter int unsigned XFER_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_lvl,
   input  logic [NLOC-1:0] mask,
   output logic            copy_en,
   output idx_t            copy_idx,
   output logic            done
);
   localparam int unsigned CW = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;

   ax_state_e       state;
   logic            start_prev;
   logic            start_rise;
   logic [NLOC-1:0] pend;
   logic [NLOC-1:0] pick;
   logic [NLOC-1:0] left;
   logic            slot_end;

   assign start_rise = start_lvl & ~start_prev;
   assign copy_idx   = first_set(pend);
   assign pick       = {{(NLOC-1){1'b0}}, 1'b1} << copy_idx;
   assign left       = pend & ~pick;
   assign copy_en    = (state == AX_RUN) && slot_end && !start_rise;

   generate
      if (XFER_CYC == 1) begin : g_noslot
         assign slot_end = 1'b1;
      end else begin : g_slot
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (start_rise) cnt <= CW'(XFER_CYC - 1);
            else if (state == AX_RUN) cnt <= (cnt == '0) ? CW'(XFER_CYC - 1) : cnt - 1'b1;
         end
         assign slot_end = (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= AX_IDLE;
         start_prev <= 1'b0;
         pend       <= '0;
         done       <= 1'b0;
      end else begin
         start_prev <= start_lvl;
         if (start_rise) begin
            pend  <= mask;
            done  <= (mask == '0);
            state <= (mask == '0) ? AX_IDLE : AX_RUN;
         end else if (copy_en) begin
            pend <= left;
            if (left == '0) begin
               done  <= 1'b1;
               state <= AX_IDLE;
            end
         end
      end
   end

   p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_rise && mask != '0) |=> !done);
   p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_rise && mask == '0) |=> done);
   p_busy_nodone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == AX_RUN) |-> !done);
   p_pend_shrink_r10: assert property (@(posedge clk) disable iff (!rst_n)
      copy_en |=> ($countones(pend) + 1 == $countones($past(pend))) || $past(start_rise));
endmodule

// File: rtl/shadow_xfer_bank.sv
module shadow_xfer_bank
   import shx_pkg::*;
#(
   parameter int unsigned   AW       = 8,
   parameter int unsigned   DW       = 32,
   parameter int unsigned   XFER_CYC = 4,
   parameter logic [DW-1:0] HW_VER   = DW'(32'h0005_0A01)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   output logic [NLOC*DW-1:0] local_flat
);
   generate
      if (DW < NLOC) begin : g_chk_dw
         $error("DW must hold one mask bit per shadowed word");
      end
      if (AW < 8) begin : g_chk_aw
         $error("AW must cover offsets up to 0xFF");
      end
      if (XFER_CYC < 1) begin : g_chk_cyc
         $error("XFER_CYC must be at least 1");
      end
   endgenerate

   logic          hi_ok;
   logic [7:0]    a8;
   logic          wr;
   logic          mwr_en;
   idx_t          widx;

   generate
      if (AW > 8) begin : g_hi
         assign hi_ok = ~|bus_addr[AW-1:8];
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign a8     = {bus_addr[7:2], 2'b00};
   assign wr     = bus_sel & bus_wr & hi_ok;
   assign widx   = a8[6:2];
   assign mwr_en = wr & ~a8[7];

   logic [NLOC-1:0] mask_q;
   logic            start_q;
   logic [IDXW:0]   wctl_q;
   logic            wctl_clr;

   assign wctl_clr = wr && (a8 == OFS_WCTL) && !bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         start_q <= 1'b0;
         wctl_q  <= '0;
      end else if (wr) begin
         if (a8 == OFS_MASK)  mask_q  <= bus_wdata[NLOC-1:0];
         if (a8 == OFS_START) start_q <= bus_wdata[0];
         if (a8 == OFS_WCTL)  wctl_q  <= bus_wdata[IDXW:0];
      end
   end

   logic            s_en;
   idx_t            s_idx;
   logic [NLOC-1:0] wstat;
   logic            a_en;
   idx_t            a_idx;
   logic            a_done;
   logic [NLOC*DW-1:0] master_flat;

   shx_single_xfer u_single (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_lvl  (wctl_q[0]),
      .sel_idx  (wctl_q[IDXW:1]),
      .clr      (wctl_clr),
      .copy_en  (s_en),
      .copy_idx (s_idx),
      .stat     (wstat)
   );

   shx_auto_xfer #(.XFER_CYC(XFER_CYC)) u_auto (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_lvl (start_q),
      .mask      (mask_q),
      .copy_en   (a_en),
      .copy_idx  (a_idx),
      .done      (a_done)
   );

   shx_bank #(.DW(DW), .HW_VER(HW_VER)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .mwr_en      (mwr_en),
      .mwr_idx     (widx),
      .mwr_data    (bus_wdata),
      .s_en        (s_en),
      .s_idx       (s_idx),
      .a_en        (a_en),
      .a_idx       (a_idx),
      .master_flat (master_flat),
      .local_flat  (local_flat)
   );

   logic [DW-1:0] mst_arr [NLOC];
   logic [DW-1:0] loc_arr [NLOC];
   genvar gi;
   generate
      for (gi = 0; gi < NLOC; gi++) begin : g_view
         assign mst_arr[gi] = master_flat[gi*DW +: DW];
         assign loc_arr[gi] = local_flat[gi*DW +: DW];
      end
   endgenerate

   idx_t rd_sel;
   assign rd_sel = loc_arr[IDX_RDSEL][IDXW-1:0];

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && hi_ok) begin
         if (!a8[7]) bus_rdata = mst_arr[widx];
         else begin
            case (a8)
               OFS_MASK:  bus_rdata = DW'(mask_q);
               OFS_START: bus_rdata = DW'(start_q);
               OFS_DONE:  bus_rdata = DW'(a_done);
               OFS_WCTL:  bus_rdata = DW'(wctl_q);
               OFS_WSTAT: bus_rdata = DW'(wstat);
               OFS_RDOUT: bus_rdata = loc_arr[rd_sel];
               default:   bus_rdata = '0;
            endcase
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:NLOC]};

   p_ver_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mst_arr[0]));
endmodule

// File: tb/sim_shadow_xfer_bank.sv
module sim_shadow_xfer_bank;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 8;
   localparam int unsigned XC = 4;
   localparam logic [31:0] VER = 32'h0005_0A01;
   localparam int unsigned NROW = 10;
   localparam logic [7:0]  T_ADDR [NROW] = '{8'h04, 8'h08, 8'h28, 8'h30, 8'h34,
                                            8'h3C, 8'h7C, 8'h00, 8'h88, 8'hA0};
   localparam logic [31:0] T_DATA [NROW] = '{32'hDEAD0001, 32'h12345678, 32'hA5A5A5A5,
                                            32'h0000FFFF, 32'h00000001, 32'h80000000,
                                            32'hCAFEF00D, 32'hFFFFFFFF, 32'h11111111,
                                            32'h22222222};
   localparam logic [31:0] T_EXP  [NROW] = '{32'hDEAD0001, 32'h12345678, 32'hA5A5A5A5,
                                            32'h0000FFFF, 32'h00000001, 32'h80000000,
                                            32'hCAFEF00D, VER, 32'h0, 32'h0};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [32*DW-1:0] local_flat;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   shadow_xfer_bank #(.AW(AW), .DW(DW), .XFER_CYC(XC), .HW_VER(VER)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .local_flat(local_flat)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] loc(input int i);
      return local_flat[i*DW +: DW];
   endfunction

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int waited;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      brd(8'h00, v); check("R1 version", v, VER);
      brd(8'h8C, v); check("R1 done", v, 32'h0);
      brd(8'h94, v); check("R1 status", v, 32'h0);
      brd(8'h98, v); check("R1 readout", v, 32'h0);
      brd(8'h04, v); check("R1 master", v, 32'h0);
      check("R1 locals", 32'(local_flat != '0), 32'h0);

      // R2 R9 table: write all rows, then read all rows
      for (int i = 0; i < NROW; i++) bwr(T_ADDR[i], T_DATA[i]);
      for (int i = 0; i < NROW; i++) begin
         brd(T_ADDR[i], v);
         check((T_ADDR[i] >= 8'h80) ? "R9 table" : "R2 table", v, T_EXP[i]);
      end
      check("R3 locals after master writes", 32'(local_flat != '0), 32'h0);

      // R4 single transfer of word 1
      bwr(8'h90, 32'h0);
      bwr(8'h90, (32'd1 << 1) | 32'd1);
      @(negedge clk);
      check("R4 local1", loc(1), 32'hDEAD0001);
      brd(8'h94, v); check("R4 status", v, 32'h2);
      check("R4 local2 untouched", loc(2), 32'h0);

      // R5 no edge, no copy
      bwr(8'h04, 32'h00000055);
      bwr(8'h90, (32'd1 << 1) | 32'd1);
      repeat (2) @(negedge clk);
      check("R5 no rise no copy", loc(1), 32'hDEAD0001);
      check("R3 master write keeps local", loc(1), 32'hDEAD0001);
      bwr(8'h90, 32'h0);
      brd(8'h94, v); check("R5 status cleared", v, 32'h0);
      bwr(8'h90, (32'd2 << 1) | 32'd1);
      @(negedge clk);
      check("R4 local2", loc(2), 32'h12345678);
      brd(8'h94, v); check("R4 status word2", v, 32'h4);
      brd(8'h90, v); check("R9 ctl readback", v, 32'h5);

      // R6 readout via selector word 18
      bwr(8'h48, 32'h2);
      bwr(8'h90, 32'h0);
      bwr(8'h90, (32'd18 << 1) | 32'd1);
      @(negedge clk);
      brd(8'h98, v); check("R6 readout word2", v, 32'h12345678);
      bwr(8'h48, 32'h7);
      @(negedge clk);
      brd(8'h98, v); check("R3 R6 selector master only", v, 32'h12345678);

      // R8 empty mask start
      bwr(8'h84, 32'h0);
      bwr(8'h84, 32'h1);
      brd(8'h8C, v); check("R8 done before edge", v, 32'h0);
      @(negedge clk);
      brd(8'h8C, v); check("R8 empty mask done", v, 32'h1);

      // R7 R10 group transfer of words 10, 12, 15
      bwr(8'h84, 32'h0);
      bwr(8'h80, (32'd1 << 10) | (32'd1 << 12) | (32'd1 << 15));
      brd(8'h80, v); check("R9 mask readback", v, 32'h00009400);
      bwr(8'h84, 32'h1);
      brd(8'h84, v); check("R9 start readback", v, 32'h1);
      brd(8'h8C, v); check("R8 done held until edge", v, 32'h1);
      @(negedge clk);
      brd(8'h8C, v); check("R8 done cleared", v, 32'h0);
      repeat (3) @(negedge clk);
      check("R7 first slot not yet", loc(10), 32'h0);
      @(negedge clk);
      check("R7 word10 copied", loc(10), 32'hA5A5A5A5);
      check("R7 word12 waits", loc(12), 32'h0);
      brd(8'h8C, v); check("R7 not done", v, 32'h0);
      repeat (4) @(negedge clk);
      check("R7 word12 copied", loc(12), 32'h0000FFFF);
      check("R7 word15 waits", loc(15), 32'h0);
      repeat (4) @(negedge clk);
      check("R7 word15 copied", loc(15), 32'h80000000);
      brd(8'h8C, v); check("R7 done", v, 32'h1);
      check("R10 word13 unselected", loc(13), 32'h0);
      check("R10 word11 unselected", loc(11), 32'h0);
      check("R10 word31 unselected", loc(31), 32'h0);

      // R7 restart completes within the slot bound
      bwr(8'h3C, 32'h0F0F0F0F);
      bwr(8'h84, 32'h0);
      bwr(8'h84, 32'h1);
      waited = 0;
      brd(8'h8C, v);
      while (v !== 32'h1 || waited < 2) begin
         @(negedge clk);
         waited++;
         brd(8'h8C, v);
         if (waited > 3 * XC + 4) break;
      end
      check("R7 restart done in time", 32'(waited <= 3 * XC + 1), 32'h1);
      check("R7 restart word15", loc(15), 32'h0F0F0F0F);

      summary();
      $finish;
   end
endmodule